// File: doc/BRIEF.md
# Supply-Fail Reset Generator with Watchdog

The block generates the system reset for a processor from two causes. The first is a synchronous flag from an external comparator that reports the supply below its trip level. The second is a watchdog that is always running. Reset stays asserted while the supply flag is active. After the flag clears, reset is held for a fixed stretch period before it is released. If the processor does not toggle its service input within the watchdog period, the block issues a reset pulse of the same stretch length.

Both periods are counted in ticks of an internal prescaler, which divides the clock by `CLK_DIV`. A test setup can therefore shrink them. The service input goes through a two-flop synchronizer, and a change in either direction counts as service. The watchdog has no enable. A service input that never changes therefore produces a reset every watchdog period plus stretch period. Two outputs are provided: an active-low reset and an active-high reset, each driven from its own register.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `uv_i` is 1 at a clock edge, both outputs show reset asserted (`rst_n_o`=0, `rst_o`=1) from the next cycle on.
- R2: After `uv_i` returns to 0, reset stays asserted until the `STRETCH_TICKS`-th prescaler tick seen with `uv_i` low. That is between (STRETCH_TICKS-1)*CLK_DIV+1 and STRETCH_TICKS*CLK_DIV cycles, and the release only happens on a tick.
- R3: If `uv_i` returns to 1 during the stretch period, the stretch count restarts, and the release is timed from the last fall of `uv_i`.
- R4: When the watchdog expires, reset is asserted for exactly STRETCH_TICKS*CLK_DIV cycles.
- R5: A rising change and a falling change of `wdi_i` each restart the watchdog, so toggling every 20 cycles with the bench parameters never causes a reset.
- R6: While reset is asserted, the watchdog count is held at zero. Counting starts at release, so with no service reset rises again exactly WDOG_TICKS*CLK_DIV cycles after a release.
- R7: The watchdog cannot be turned off. A constant `wdi_i` gives a periodic reset with a period of (WDOG_TICKS+STRETCH_TICKS)*CLK_DIV cycles.
- R8: `rst_o` is the inverse of `rst_n_o` in every cycle.
- R9: While `rst_ni` is 0, reset is asserted. After `rst_ni` is released with `uv_i` low, the block runs a full stretch period before release, as if the supply had just recovered.
- R10: If a synchronized service edge falls in the same cycle as the watchdog expiry tick, the service edge wins and no reset is produced.
- R11: A change of `wdi_i` takes effect on the watchdog at the third rising clock edge after the change, because of the two-flop synchronizer and the edge register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| uv_i | input | 1 | Synchronous supply-below-threshold flag |
| wdi_i | input | 1 | Watchdog service input, asynchronous |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
The bench places a service edge exactly on the watchdog expiry tick. A design where the timeout takes priority would drop reset three cycles later. It runs the watchdog with a stuck input and measures the high and low times exactly. A watchdog that kept counting during the reset pulse would show a shortened high time, and an off-by-one counter would miss the stretch length by a whole prescaler tick. It also pulls the supply flag back up in the middle of a stretch. A design that only resumes its count would release too early. A table of service gaps, together with a steady toggle, catches a design that accepts only one edge direction, because such a design would reset at the doubled interval.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {
    SUP_ASSERT = 1'b0,
    SUP_RUN    = 1'b1
  } sup_state_e;
endpackage

// File: rtl/sup_prescale.sv
module sup_prescale #(
  parameter int DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sup_svc_edge.sv
module sup_svc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic svc_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], svc_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // either direction counts as service
  assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int STRETCH_TICKS = 200,
  parameter int WDOG_TICKS    = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic uv_i,
  input  logic svc_edge_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam int WW = $clog2(WDOG_TICKS + 1);
  localparam logic [SW-1:0] ST_LAST = SW'(STRETCH_TICKS - 1);
  localparam logic [WW-1:0] WD_LAST = WW'(WDOG_TICKS - 1);

  sup_state_e    state_q, state_d;
  logic [SW-1:0] st_cnt_q, st_cnt_d;
  logic [WW-1:0] wd_cnt_q, wd_cnt_d;

  always_comb begin
    state_d  = state_q;
    st_cnt_d = st_cnt_q;
    wd_cnt_d = wd_cnt_q;
    if (uv_i) begin
      state_d  = SUP_ASSERT;
      st_cnt_d = '0;
      wd_cnt_d = '0;
    end else if (state_q == SUP_ASSERT) begin
      wd_cnt_d = '0;
      if (tick_i) begin
        if (st_cnt_q == ST_LAST) begin
          state_d  = SUP_RUN;
          st_cnt_d = '0;
        end else begin
          st_cnt_d = st_cnt_q + 1'b1;
        end
      end
    end else begin
      // service beats an expiry in the same cycle
      if (svc_edge_i) begin
        wd_cnt_d = '0;
      end else if (tick_i) begin
        if (wd_cnt_q == WD_LAST) begin
          state_d  = SUP_ASSERT;
          st_cnt_d = '0;
          wd_cnt_d = '0;
        end else begin
          wd_cnt_d = wd_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SUP_ASSERT;
      st_cnt_q <= '0;
      wd_cnt_q <= '0;
      rst_n_o  <= 1'b0;
      rst_o    <= 1'b1;
    end else begin
      state_q  <= state_d;
      st_cnt_q <= st_cnt_d;
      wd_cnt_q <= wd_cnt_d;
      rst_n_o  <= (state_d == SUP_RUN);
      rst_o    <= (state_d != SUP_RUN);
    end
  end
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int CLK_DIV       = 1000,
  parameter int STRETCH_TICKS = 200,
  parameter int WDOG_TICKS    = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  input  logic wdi_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic tick;
  logic svc_edge;

  sup_prescale #(.DIV(CLK_DIV)) i_prescale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sup_svc_edge #(.SYNC_STAGES(2)) i_svc_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .svc_i (wdi_i),
    .edge_o(svc_edge)
  );

  sup_ctrl #(
    .STRETCH_TICKS(STRETCH_TICKS),
    .WDOG_TICKS   (WDOG_TICKS)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .uv_i      (uv_i),
    .svc_edge_i(svc_edge),
    .rst_n_o   (rst_n_o),
    .rst_o     (rst_o)
  );
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uv_i,
  input logic tick_i,
  input logic svc_edge_i,
  input logic rst_n_o,
  input logic rst_o
);
  a_r1_uv_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !rst_n_o);

  a_r2_release_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_o) |-> !$past(uv_i));

  a_r2_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_o) |-> $past(tick_i));

  a_r4_assert_on_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_n_o) |-> ($past(uv_i) || $past(tick_i)));

  a_r8_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_n_o);

  a_r10_service_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_edge_i && rst_n_o && !uv_i) |=> rst_n_o);
endmodule

bind sup_reset_wdog sup_reset_wdog_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .uv_i      (uv_i),
  .tick_i    (tick),
  .svc_edge_i(svc_edge),
  .rst_n_o   (rst_n_o),
  .rst_o     (rst_o)
);

// File: tb/test_sup_reset_wdog.sv
module test_sup_reset_wdog;
  localparam int D = 3;
  localparam int S = 5;
  localparam int W = 8;
  localparam int ST_MIN = (S - 1) * D + 1;
  localparam int ST_MAX = S * D;

  typedef struct packed {
    logic [7:0] gap;
    logic       rst;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'd6, 1'b0}, '{8'd20, 1'b0}, '{8'd1, 1'b0}, '{8'd2, 1'b0},
    '{8'd30, 1'b1}, '{8'd15, 1'b0}, '{8'd40, 1'b1}, '{8'd20, 1'b0},
    '{8'd28, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic uv = 1'b0;
  logic wdi = 1'b0;
  logic rst_n_o, rst_o;
  int n_chk = 0;
  int n_bad = 0;
  int mism = 0;

  always #4 clk = ~clk;

  sup_reset_wdog #(.CLK_DIV(D), .STRETCH_TICKS(S), .WDOG_TICKS(W)) i_sup_reset_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .uv_i(uv), .wdi_i(wdi),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  always @(negedge clk) if (rst_o !== ~rst_n_o) mism++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (rst_n_o !== lvl && n < 400) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, lows;
    @(negedge clk);
    repeat (3) step();
    chk(rst_n_o == 1'b0 && rst_o == 1'b1, "R9 reset state", rst_n_o, 0);
    rst_ni = 1'b1;
    wait_level(1'b1, n);
    chk(n >= ST_MIN && n <= ST_MAX + 1, "R9 power-on stretch", n, ST_MAX);

    // R1: supply flag holds reset
    uv = 1'b1;
    step();
    chk(rst_n_o == 1'b0, "R1 immediate assert", rst_n_o, 0);
    lows = 0;
    repeat (50) begin step(); if (rst_n_o == 1'b0) lows++; end
    chk(lows == 50, "R1 held while flag high", lows, 50);

    // R2: stretch after flag clears
    uv = 1'b0;
    wait_level(1'b1, n);
    chk(n >= ST_MIN && n <= ST_MAX, "R2 stretch length", n, ST_MAX);

    // R3: restart during stretch
    uv = 1'b1;
    repeat (5) step();
    uv = 1'b0;
    repeat (8) step();
    chk(rst_n_o == 1'b0, "R3 still in stretch", rst_n_o, 0);
    uv = 1'b1;
    repeat (2) step();
    uv = 1'b0;
    wait_level(1'b1, n);
    chk(n >= ST_MIN && n <= ST_MAX, "R3 restarted stretch", n, ST_MAX);

    // R6/R4/R7: stuck service input, exact periods
    wait_level(1'b0, n);
    chk(n == W * D, "R6 high time from release", n, W * D);
    wait_level(1'b1, lows);
    chk(lows == S * D, "R4 watchdog pulse length", lows, S * D);
    wait_level(1'b0, n);
    wait_level(1'b1, lows);
    chk(n + lows == (S + W) * D, "R7 periodic reset", n + lows, (S + W) * D);

    // R10/R11: service edge on the expiry tick
    repeat (W * D - 3) step();
    wdi = ~wdi;
    lows = 0;
    repeat (10) begin step(); if (rst_n_o == 1'b0) lows++; end
    chk(lows == 0, "R10 service wins tie", lows, 0);
    wait_level(1'b0, n);
    chk(n + 10 == W * D + 3, "R11 sync latency", n + 10, W * D + 3);
    wait_level(1'b1, n);

    // table of service gaps
    for (int i = 0; i < NV; i++) begin
      wdi = ~wdi;
      lows = 0;
      for (int k = 0; k < int'(VEC[i].gap); k++) begin
        step();
        if (rst_n_o == 1'b0) lows = 1;
      end
      chk(lows == int'(VEC[i].rst), VEC[i].rst ? "R4 late service" : "R5 timely service",
          lows, int'(VEC[i].rst));
      wait_level(1'b1, n);
    end

    // R5: alternate edges every 20 cycles
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      wdi = ~wdi;
      repeat (20) begin step(); if (rst_n_o == 1'b0) lows++; end
    end
    chk(lows == 0, "R5 both edges service", lows, 0);

    // R1 from run state
    uv = 1'b1;
    step();
    chk(rst_n_o == 1'b0 && rst_o == 1'b1, "R1 assert from run", rst_n_o, 0);
    uv = 1'b0;
    wait_level(1'b1, n);

    chk(mism == 0, "R8 outputs complementary", mism, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule